// File: doc/BRIEF.md
# Two-Channel Disk Port Address Decoder

This block sits between a host I/O bus and a two-channel disk host adapter. It examines every 16-bit I/O address with a read or write strobe. It reports which channel is addressed and whether the target is one of that channel's eight command registers or its single control register. For command hits it also gives the register offset.

The block has two address maps. In the fixed (legacy) map each channel sits at its traditional port range and drives its own interrupt line. In the programmable (native) map the port bases come from software-loaded base inputs, and the two device interrupts merge into one shared line.

A one-bit map register chooses between the two maps. Reset clears it to the fixed map, and a load strobe changes it. Bus cycle timing is generated elsewhere.

Top module: `ata_port_decode`

## Requirements
- R1: Reset leaves `native_mode` low (fixed map). While `mode_ld` is high at a rising clock edge, `native_mode` takes `mode_native_in`; otherwise it holds.
- R2: In the fixed map, addresses 0x1F0..0x1F7 select the primary channel's command registers and 0x3F6 selects its control register. The base inputs have no effect in this map.
- R3: In the fixed map, addresses 0x170..0x177 select the secondary channel's command registers and 0x376 selects its control register.
- R4: On a command hit `sel_cmd` is high and `reg_ofs` equals address bits [2:0]. On a control hit `sel_ctl` is high and `reg_ofs` is 0. The two are never high together.
- R5: `word16` is high only for a command hit at offset 0 (the 16-bit data register). Every other register is 8 bits wide and keeps `word16` low.
- R6: In the programmable map, a command hit is an address whose bits [15:3] equal those of the channel's command base. A control hit is an address exactly equal to the channel's control base. The fixed-map addresses then decode only if they fall in a programmed window.
- R7: An address that hits neither channel raises no select, and `rd_oe` stays low, so the data bus is left undriven.
- R8: Selects are raised only while `io_rd` or `io_wr` is high. `rd_oe` is high exactly when `io_rd` is high and a channel is selected.
- R9: If an address falls in a window of both channels, only the primary channel is selected. Within one channel, a command hit takes precedence over a control hit.
- R10: In the fixed map, `irq14` follows `dev_irq_pri`, `irq15` follows `dev_irq_sec`, and `irq_shared` is low.
- R11: In the programmable map, `irq_shared` is the OR of both device requests, and `irq14` and `irq15` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the map register |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ld | input | 1 | Load strobe for the map register |
| mode_native_in | input | 1 | Map value to load: 1 programmable, 0 fixed |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Read strobe, active high |
| io_wr | input | 1 | Write strobe, active high |
| pri_cmd_base | input | 16 | Primary command window base (programmable map) |
| pri_ctl_base | input | 16 | Primary control port address (programmable map) |
| sec_cmd_base | input | 16 | Secondary command window base (programmable map) |
| sec_ctl_base | input | 16 | Secondary control port address (programmable map) |
| dev_irq_pri | input | 1 | Primary device interrupt request |
| dev_irq_sec | input | 1 | Secondary device interrupt request |
| native_mode | output | 1 | Current map: 1 programmable |
| sel_pri | output | 1 | Primary channel selected |
| sel_sec | output | 1 | Secondary channel selected |
| sel_cmd | output | 1 | Command register addressed |
| sel_ctl | output | 1 | Control register addressed |
| reg_ofs | output | 3 | Command register offset |
| word16 | output | 1 | Access targets the 16-bit data register |
| rd_oe | output | 1 | Drive read data onto the host bus |
| irq14 | output | 1 | Primary interrupt, fixed map |
| irq15 | output | 1 | Secondary interrupt, fixed map |
| irq_shared | output | 1 | Combined interrupt, programmable map |

## Verification
The bench probes the edges of each window: 0x1F0 and 0x1F7 must hit, while 0x1F8 and 0x16F must miss. A decoder that compares too few address bits would claim the neighbours, and one that compares too many would lose part of the range. It also uses 0x3F7, next to the control port: a design that masks low bits on the control compare would select it.

In the programmable map, the bench checks that the fixed addresses go dark. It also deliberately gives both channels the same command base; a design without primary priority would raise both selects at once. Interrupt routing is driven with all four request combinations in each map, which catches swapped lines and a shared line that leaks into the fixed map.

// File: rtl/ata_port_decode.sv
module ata_port_decode #(
  parameter int AW = 16,
  parameter int OW = 3,
  parameter logic [AW-1:0] LEG_PRI_CMD = 16'h01F0,
  parameter logic [AW-1:0] LEG_PRI_CTL = 16'h03F6,
  parameter logic [AW-1:0] LEG_SEC_CMD = 16'h0170,
  parameter logic [AW-1:0] LEG_SEC_CTL = 16'h0376
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ld,
  input  logic          mode_native_in,
  input  logic [AW-1:0] io_addr,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [AW-1:0] pri_cmd_base,
  input  logic [AW-1:0] pri_ctl_base,
  input  logic [AW-1:0] sec_cmd_base,
  input  logic [AW-1:0] sec_ctl_base,
  input  logic          dev_irq_pri,
  input  logic          dev_irq_sec,
  output logic          native_mode,
  output logic          sel_pri,
  output logic          sel_sec,
  output logic          sel_cmd,
  output logic          sel_ctl,
  output logic [OW-1:0] reg_ofs,
  output logic          word16,
  output logic          rd_oe,
  output logic          irq14,
  output logic          irq15,
  output logic          irq_shared
);

  logic          mode_q;
  logic [AW-1:0] pcmd, pctl, scmd, sctl;
  logic          p_cmd_hit, p_ctl_hit, s_cmd_hit, s_ctl_hit;
  logic          p_any, s_any, strobe, any_sel, cmd_eff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_ld) mode_q <= mode_native_in;

  assign native_mode = mode_q;

  assign pcmd = mode_q ? pri_cmd_base : LEG_PRI_CMD;
  assign pctl = mode_q ? pri_ctl_base : LEG_PRI_CTL;
  assign scmd = mode_q ? sec_cmd_base : LEG_SEC_CMD;
  assign sctl = mode_q ? sec_ctl_base : LEG_SEC_CTL;

  assign p_cmd_hit = io_addr[AW-1:OW] == pcmd[AW-1:OW];
  assign p_ctl_hit = io_addr == pctl;
  assign s_cmd_hit = io_addr[AW-1:OW] == scmd[AW-1:OW];
  assign s_ctl_hit = io_addr == sctl;

  assign p_any  = p_cmd_hit | p_ctl_hit;
  assign s_any  = s_cmd_hit | s_ctl_hit;
  assign strobe = io_rd | io_wr;

  assign sel_pri = strobe & p_any;
  assign sel_sec = strobe & ~p_any & s_any;
  assign any_sel = sel_pri | sel_sec;

  assign cmd_eff = p_any ? p_cmd_hit : s_cmd_hit;
  assign sel_cmd = any_sel & cmd_eff;
  assign sel_ctl = any_sel & ~cmd_eff;
  assign reg_ofs = sel_cmd ? io_addr[OW-1:0] : '0;
  assign word16  = sel_cmd & (io_addr[OW-1:0] == '0);
  assign rd_oe   = io_rd & any_sel;

  assign irq14      = ~mode_q & dev_irq_pri;
  assign irq15      = ~mode_q & dev_irq_sec;
  assign irq_shared =  mode_q & (dev_irq_pri | dev_irq_sec);

endmodule

// File: rtl/ata_port_decode_chk.sv
module ata_port_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_ld,
  input logic        mode_native_in,
  input logic [15:0] io_addr,
  input logic        io_rd,
  input logic        io_wr,
  input logic        dev_irq_pri,
  input logic        dev_irq_sec,
  input logic        native_mode,
  input logic        sel_pri,
  input logic        sel_sec,
  input logic        sel_cmd,
  input logic        sel_ctl,
  input logic [2:0]  reg_ofs,
  input logic        word16,
  input logic        rd_oe,
  input logic        irq14,
  input logic        irq15,
  input logic        irq_shared
);

  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ld |=> native_mode == $past(native_mode));
  p_mode_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ld |=> native_mode == $past(mode_native_in));
  p_leg_pri_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!native_mode && io_rd && io_addr[15:3] == 13'h03E) |-> sel_pri && sel_cmd);
  p_leg_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!native_mode && io_wr && io_addr == 16'h0376) |-> sel_sec && sel_ctl);
  p_kind_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_cmd, sel_ctl}) && ((sel_cmd || sel_ctl) == (sel_pri || sel_sec)));
  p_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word16 |-> sel_cmd && reg_ofs == 3'd0);
  p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd || io_wr) |-> !sel_pri && !sel_sec && !rd_oe);
  p_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> io_rd && (sel_pri || sel_sec));
  p_chan_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_pri, sel_sec}));
  p_irq_leg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !native_mode |-> irq14 == dev_irq_pri && irq15 == dev_irq_sec && !irq_shared);
  p_irq_nat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    native_mode |-> !irq14 && !irq15 && irq_shared == (dev_irq_pri || dev_irq_sec));

endmodule

bind ata_port_decode ata_port_decode_chk u_chk (.*);

// File: tb/ata_port_decode_test.sv
module ata_port_decode_test;
  logic clk = 0, rst_n = 0, mode_ld = 0, mode_native_in = 0;
  logic [15:0] io_addr = 0, pri_cmd_base = 0, pri_ctl_base = 0, sec_cmd_base = 0, sec_ctl_base = 0;
  logic io_rd = 0, io_wr = 0, dev_irq_pri = 0, dev_irq_sec = 0;
  logic native_mode, sel_pri, sel_sec, sel_cmd, sel_ctl, word16, rd_oe, irq14, irq15, irq_shared;
  logic [2:0] reg_ofs;

  int total = 0, bad = 0;
  bit nat = 0, done = 0;
  logic [11:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  ata_port_decode uut (.*);

  function automatic logic [11:0] model(logic [15:0] a, logic rd, logic wr, logic n, logic ip, logic is);
    logic [15:0] pc, pk, sc, sk;
    logic ph, pk_h, sh, sk_h, sp, ss, c, k, w;
    logic [2:0] o;
    pc = n ? pri_cmd_base : 16'h01F0; pk = n ? pri_ctl_base : 16'h03F6;
    sc = n ? sec_cmd_base : 16'h0170; sk = n ? sec_ctl_base : 16'h0376;
    ph = (a & 16'hFFF8) == (pc & 16'hFFF8); pk_h = a == pk;
    sh = (a & 16'hFFF8) == (sc & 16'hFFF8); sk_h = a == sk;
    sp = (rd | wr) & (ph | pk_h);
    ss = (rd | wr) & !(ph | pk_h) & (sh | sk_h);
    c = sp ? ph : (ss ? sh : 1'b0);
    k = (sp | ss) & !c;
    o = c ? a[2:0] : 3'd0;
    w = c & (a[2:0] == 3'd0);
    return {sp, ss, c, k, o, w, rd & (sp | ss), !n & ip, !n & is, n & (ip | is)};
  endfunction

  task automatic apply(logic [15:0] a, logic rd, logic wr, logic ip, logic is, string tag);
    @(posedge clk); #1;
    io_addr = a; io_rd = rd; io_wr = wr; dev_irq_pri = ip; dev_irq_sec = is;
    exp_q.push_back(model(a, rd, wr, nat, ip, is));
    tag_q.push_back(tag);
  endtask

  task automatic set_mode(logic n);
    @(posedge clk); #1;
    io_rd = 0; io_wr = 0; mode_ld = 1; mode_native_in = n;
    @(posedge clk); #1;
    mode_ld = 0; mode_native_in = ~n; nat = n;
    @(negedge clk);
    total++;
    if (native_mode !== n) begin
      bad++;
      $display("FAIL R1 mode load: actual=%0b expected=%0b", native_mode, n);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [11:0] e, act;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      act = {sel_pri, sel_sec, sel_cmd, sel_ctl, reg_ofs, word16, rd_oe, irq14, irq15, irq_shared};
      total++;
      if (act !== e) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", t, act, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    pri_cmd_base = 16'hC000; pri_ctl_base = 16'hC00A;
    sec_cmd_base = 16'hC010; sec_ctl_base = 16'hC01A;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    total++;
    if (native_mode !== 1'b0 || sel_pri !== 0 || sel_sec !== 0 || rd_oe !== 0) begin
      bad++;
      $display("FAIL R1 reset: actual=%b expected=0", {native_mode, sel_pri, sel_sec, rd_oe});
    end
    // fixed map
    apply(16'h01F0, 1, 0, 0, 0, "R2 R5 pri data");
    apply(16'h01F7, 0, 1, 0, 0, "R2 R4 pri top");
    apply(16'h01F3, 1, 0, 0, 0, "R4 pri ofs3");
    apply(16'h03F6, 1, 0, 0, 0, "R2 R4 pri ctl");
    apply(16'h0170, 0, 1, 0, 0, "R3 R5 sec data");
    apply(16'h0177, 1, 0, 0, 0, "R3 sec top");
    apply(16'h0376, 1, 0, 0, 0, "R3 sec ctl");
    apply(16'h03F7, 1, 0, 0, 0, "R7 beside ctl");
    apply(16'h01F8, 1, 0, 0, 0, "R7 above pri");
    apply(16'h016F, 1, 0, 0, 0, "R7 below sec");
    apply(16'hC003, 1, 0, 0, 0, "R2 bases ignored");
    apply(16'h01F2, 0, 0, 0, 0, "R8 no strobe");
    apply(16'h0172, 0, 1, 0, 0, "R8 write no oe");
    for (int i = 0; i < 4; i++) apply(16'h0000, 0, 0, i[0], i[1], "R10 irq fixed");
    // programmable map
    set_mode(1);
    apply(16'hC000, 1, 0, 0, 0, "R6 R5 nat pri data");
    apply(16'hC005, 0, 1, 0, 0, "R6 nat pri ofs5");
    apply(16'hC00A, 1, 0, 0, 0, "R6 nat pri ctl");
    apply(16'hC017, 1, 0, 0, 0, "R6 nat sec top");
    apply(16'hC01A, 0, 1, 0, 0, "R6 nat sec ctl");
    apply(16'h01F0, 1, 0, 0, 0, "R6 R7 fixed addr dark");
    apply(16'h0376, 1, 0, 0, 0, "R6 R7 fixed ctl dark");
    apply(16'hC01B, 1, 0, 0, 0, "R7 beside nat ctl");
    for (int i = 0; i < 4; i++) apply(16'h0000, 0, 0, i[0], i[1], "R11 irq shared");
    @(posedge clk); #1;
    sec_cmd_base = 16'hC000;
    apply(16'hC004, 1, 0, 0, 0, "R9 overlap pri wins");
    @(posedge clk); #1;
    sec_cmd_base = 16'hC010; pri_ctl_base = 16'hC002;
    apply(16'hC002, 1, 0, 0, 0, "R9 cmd over ctl");
    @(posedge clk); #1;
    pri_ctl_base = 16'hC00A;
    // back to fixed map
    set_mode(0);
    apply(16'h03F6, 0, 1, 1, 1, "R2 R10 fixed again");
    apply(16'hC010, 1, 0, 0, 1, "R2 bases ignored again");
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule